// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

The block takes one fast input clock and derives two slower clocks from it. The "pair" output runs at one half or one quarter of the input rate. The "trio" output runs at one quarter, one fifth or one sixth of the input rate. Both dividers advance on the same rising input edges and restart together. As a result, every rising edge that the two outputs have in common falls on the same input edge, and the two stay aligned even when no reset is ever applied.

A run enable starts and stops both dividers together. The enable is captured on the falling edge of the input clock, so the dividers only start or stop while the internal clock is low. A stopped divider holds its output level, and no high or low phase is ever shortened. An active-low master reset, sampled on the rising edge, puts both dividers into a known phase. Several copies released from reset on the same edge therefore run in lock-step. The ratio selects are meant to be static. A change is taken up only when both dividers reach the end of their shared period.

Top module: `clkdiv_dual`

## Requirements
- R1: With `sel_pair` = 0, `out_pair` has a period of 2 enabled input edges and is high for 1 of them. With `sel_pair` = 1, the period is 4 edges, high for 2.
- R2: `sel_trio` selects the trio period as follows: 2'b00 gives 4 edges (high 2), 2'b01 gives 5 edges (high 2, low 3), 2'b10 gives 6 edges (high 3), and 2'b11 also gives 6 edges (high 3).
- R3: On the first enabled rising edge after reset, both outputs rise. After that, both outputs rise together on every edge where a whole number of periods of each divider has elapsed.
- R4: `run_en` is sampled on the falling input edge. The level it has at that falling edge decides whether the next rising edge advances the dividers.
- R5: While the sampled enable is low, both outputs hold their level. Across any pattern of enable toggles, every high or low phase lasts at least its full number of enabled edges, so no runt pulse appears.
- R6: `rst_n` low on a rising edge drives both outputs low, clears the sampled enable and reloads the divider phase.
- R7: A select change takes effect only on the edge where both dividers end their period together. Until that edge, the old ratios continue.
- R8: Whenever both active ratios equal 4, `out_pair` and `out_trio` are identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Master reset, active low, sampled on the rising edge |
| run_en | input | 1 | Run enable, sampled on the falling edge |
| sel_pair | input | 1 | Pair ratio select: 0 gives ÷2, 1 gives ÷4 |
| sel_trio | input | 2 | Trio ratio select: 00 gives ÷4, 01 gives ÷5, 10 or 11 gives ÷6 |
| out_pair | output | 1 | Divided clock at ÷2 or ÷4 |
| out_trio | output | 1 | Divided clock at ÷4, ÷5 or ÷6 |

## Verification
A wrong phase count in either divider shows at its output within one period of at most six enabled edges. It appears as a rise out of step with the other output, or as a phase of the wrong length. A mis-sampled enable shifts an output transition by exactly one input edge, so it shows on the first edge after the toggle. Latching a select at the wrong moment breaks the shared rising edge at the next joint period boundary, which is at most twenty edges away.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and select encodings for the dual-ratio divider.
// Assumes exactly two divider lanes: index 0 is the pair lane, index 1 the trio lane.
package clkdiv_pkg;

    localparam int NUM_DIV  = 2;
    localparam int PAIR_IDX = 0;
    localparam int TRIO_IDX = 1;

    // Trio lane ratio select encoding (11 aliases the /6 setting)
    typedef enum logic [1:0] {
        TRIO_DIV4     = 2'b00,
        TRIO_DIV5     = 2'b01,
        TRIO_DIV6     = 2'b10,
        TRIO_DIV6_ALT = 2'b11
    } trio_sel_e;

endpackage

// File: rtl/clkdiv_enable_sync.sv
// Module: captures the run enable on the falling input edge.
// The result changes only while the input clock is low, so using it as a
// clock enable for rising-edge logic behaves like a glitch-free gated clock.
// Assumes rst_n is synchronous and active low.
module clkdiv_enable_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_q
);

    // Falling-edge capture of the enable, cleared by reset
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_in;
        end
    end

endmodule

// File: rtl/clkdiv_ratio_ctrl.sv
// Module: decodes the ratio selects and holds the active ratio of each lane.
// New ratios are adopted only at reset or on the enabled edge where every
// lane reaches its terminal count together, which keeps the lanes aligned.
// Assumes last[] reflects the active ratios, never the pending ones.
module clkdiv_ratio_ctrl
    import clkdiv_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int PAIR_LO = 2,
    parameter int PAIR_HI = 4,
    parameter int TRIO_R0 = 4,
    parameter int TRIO_R1 = 5,
    parameter int TRIO_R2 = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic                           sel_pair,
    input  logic [1:0]                     sel_trio,
    input  logic [NUM_DIV-1:0]             last,
    output logic [NUM_DIV-1:0][CNT_W:0]    ratio_act,
    output logic [NUM_DIV-1:0][CNT_W:0]    ratio_use
);

    localparam int RW = CNT_W + 1;

    logic [NUM_DIV-1:0][CNT_W:0] ratio_dec;
    logic                        joint_wrap;
    logic                        load;

    // Decode both select inputs into ratio values
    always_comb begin
        ratio_dec[PAIR_IDX] = sel_pair ? RW'(PAIR_HI) : RW'(PAIR_LO);
        case (trio_sel_e'(sel_trio))
            TRIO_DIV4: ratio_dec[TRIO_IDX] = RW'(TRIO_R0);
            TRIO_DIV5: ratio_dec[TRIO_IDX] = RW'(TRIO_R1);
            default:   ratio_dec[TRIO_IDX] = RW'(TRIO_R2);
        endcase
    end

    // Joint terminal count: every lane ends its period on this enabled edge
    always_comb begin
        joint_wrap = tick && (&last);
        load       = !rst_n || joint_wrap;
        ratio_use  = load ? ratio_dec : ratio_act;
    end

    // Hold the active ratios; reload them at reset or at a joint wrap
    always_ff @(posedge clk) begin
        if (load) begin
            ratio_act <= ratio_dec;
        end
    end

endmodule

// File: rtl/clkdiv_phase_counter.sv
// Module: one divider lane. Counts enabled edges modulo the active ratio and
// drives a registered output that is high for the first floor(ratio/2)
// counts of each period.
// Assumes ratio values from 2 up to 2**CNT_W. Reset parks the count at its
// terminal value, so the first enabled edge starts a fresh period with the
// output rising.
module clkdiv_phase_counter #(
    parameter int CNT_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [CNT_W:0] ratio_act,
    input  logic [CNT_W:0] ratio_use,
    output logic           last,
    output logic           div_out
);

    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W:0]   ratio_m1;
    logic [CNT_W:0]   high_len;

    // Terminal detect and next count
    always_comb begin
        last     = ({1'b0, cnt} == (ratio_act - ONE));
        cnt_nxt  = last ? '0 : cnt + 1'b1;
        ratio_m1 = ratio_use - ONE;
        high_len = ratio_use >> 1;
    end

    // Count enabled edges and register the divided output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= ratio_m1[CNT_W-1:0];
            div_out <= 1'b0;
        end else if (tick) begin
            cnt     <= cnt_nxt;
            div_out <= ({1'b0, cnt_nxt} < high_len);
        end
    end

endmodule

// File: rtl/clkdiv_dual.sv
// Module: top of the dual-ratio synchronous divider.
// Both lanes share one clock, one enable sampled on the falling edge, and one
// joint reload point, so rising edges the two outputs have in common coincide.
// Assumes the selects are quasi-static and rst_n is synchronous, active low.
module clkdiv_dual
    import clkdiv_pkg::*;
#(
    parameter int PAIR_LO = 2,
    parameter int PAIR_HI = 4,
    parameter int TRIO_R0 = 4,
    parameter int TRIO_R1 = 5,
    parameter int TRIO_R2 = 6
) (
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       sel_pair,
    input  logic [1:0] sel_trio,
    output logic       out_pair,
    output logic       out_trio
);

    localparam int MAX_PAIR  = (PAIR_HI > PAIR_LO) ? PAIR_HI : PAIR_LO;
    localparam int MAX_T01   = (TRIO_R1 > TRIO_R0) ? TRIO_R1 : TRIO_R0;
    localparam int MAX_TRIO  = (TRIO_R2 > MAX_T01) ? TRIO_R2 : MAX_T01;
    localparam int RATIO_MAX = (MAX_TRIO > MAX_PAIR) ? MAX_TRIO : MAX_PAIR;
    localparam int CNT_W     = (RATIO_MAX > 2) ? $clog2(RATIO_MAX) : 1;

    logic                        en_q;
    logic [NUM_DIV-1:0]          last;
    logic [NUM_DIV-1:0]          div_q;
    logic [NUM_DIV-1:0][CNT_W:0] ratio_act;
    logic [NUM_DIV-1:0][CNT_W:0] ratio_use;

    clkdiv_enable_sync u_en (
        .clk   (clk_in),
        .rst_n (rst_n),
        .en_in (run_en),
        .en_q  (en_q)
    );

    clkdiv_ratio_ctrl #(
        .CNT_W   (CNT_W),
        .PAIR_LO (PAIR_LO),
        .PAIR_HI (PAIR_HI),
        .TRIO_R0 (TRIO_R0),
        .TRIO_R1 (TRIO_R1),
        .TRIO_R2 (TRIO_R2)
    ) u_ratio (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .tick      (en_q),
        .sel_pair  (sel_pair),
        .sel_trio  (sel_trio),
        .last      (last),
        .ratio_act (ratio_act),
        .ratio_use (ratio_use)
    );

    // One counter lane per output, all advanced by the same enabled edges
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_lane
        clkdiv_phase_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk_in),
            .rst_n     (rst_n),
            .tick      (en_q),
            .ratio_act (ratio_act[g]),
            .ratio_use (ratio_use[g]),
            .last      (last[g]),
            .div_out   (div_q[g])
        );
    end

    // Route lane outputs to the ports
    always_comb begin
        out_pair = div_q[PAIR_IDX];
        out_trio = div_q[TRIO_IDX];
    end

endmodule

// File: rtl/clkdiv_dual_chk.sv
// Module: property checker for clkdiv_dual, attached with bind below.
// Observes the ports, the falling-edge enable and the active ratios.
module clkdiv_dual_chk
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic                        clk_in,
    input logic                        rst_n,
    input logic                        en_q,
    input logic                        out_pair,
    input logic                        out_trio,
    input logic [NUM_DIV-1:0][CNT_W:0] ratio_act
);

    localparam logic [CNT_W:0] FOUR = 4;

    logic rst_seen = 1'b0;

    // Remember that the last rising edge applied reset
    always_ff @(posedge clk_in) begin
        rst_seen <= !rst_n;
    end

    // After a reset edge, both outputs are low (R6)
    always @(negedge clk_in) begin
        if (rst_seen) begin
            assert_reset_low_R6: assert (!out_pair && !out_trio)
                else $error("outputs not low after reset");
        end
    end

    // A disabled edge leaves both outputs unchanged (R5)
    assert_hold_when_off_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        !en_q |=> ($stable(out_pair) && $stable(out_trio)));

    // Equal ratios of 4 give identical waveforms (R8)
    assert_equal_ratio_match_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
        (ratio_act[PAIR_IDX] == FOUR && ratio_act[TRIO_IDX] == FOUR) |-> (out_pair == out_trio));

    // A trio high phase is never shorter than two edges (R5)
    assert_trio_no_runt_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($fell(out_trio) && $past(rst_n)) |-> $past(out_trio, 2));

    // Outputs move only on edges the sampled enable allowed (R4)
    assert_move_needs_en_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && ($changed(out_pair) || $changed(out_trio))) |-> $past(en_q));

endmodule

bind clkdiv_dual clkdiv_dual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .out_pair  (out_pair),
    .out_trio  (out_trio),
    .ratio_act (ratio_act)
);

// File: tb/sim_clkdiv_dual.sv
`timescale 1ns/1ps
// Bench: sweeps every select combination, random enable toggling, select
// changes and reset, comparing both outputs with an arithmetic model.
module sim_clkdiv_dual;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       sel_pair = 1'b0;
    logic [1:0] sel_trio = 2'b00;
    logic       out_pair;
    logic       out_trio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic en_m = 1'b0;
    int   n_m = 0, ra_m = 2, rb_m = 4;
    logic ea = 1'b0, eb = 1'b0;

    // period tracking
    bit   per_on = 1'b0;
    int   sidx = 0, rise_a = -1, rise_b = -1;
    logic prev_a = 1'b0, prev_b = 1'b0;

    always #4 clk = ~clk;

    clkdiv_dual u0 (
        .clk_in   (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .sel_pair (sel_pair),
        .sel_trio (sel_trio),
        .out_pair (out_pair),
        .out_trio (out_trio)
    );

    function automatic int gcd(int a, int b);
        while (b != 0) begin
            int t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int trio_ratio(logic [1:0] s);
        return (s == 2'b00) ? 4 : (s == 2'b01) ? 5 : 6;
    endfunction

    // model: enable seen at the falling edge
    always @(negedge clk) en_m <= rst_n ? run_en : 1'b0;

    // model: advance phase on enabled rising edges
    always @(posedge clk) begin
        if (!rst_n) begin
            n_m = 0; ea = 1'b0; eb = 1'b0;
        end else if (en_m) begin
            if (n_m % (ra_m * rb_m / gcd(ra_m, rb_m)) == 0) begin
                ra_m = sel_pair ? 4 : 2;
                rb_m = trio_ratio(sel_trio);
                n_m  = 0;
            end
            n_m = n_m + 1;
            ea = ((n_m - 1) % ra_m) < (ra_m / 2);
            eb = ((n_m - 1) % rb_m) < (rb_m / 2);
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // one rising edge, then compare outputs with the model
    task automatic step(string ta, string tb);
        @(posedge clk);
        #2;
        sidx++;
        chk(ta, out_pair, ea);
        chk(tb, out_trio, eb);
        if (ea && !prev_a && eb && !prev_b) chk("R3", out_pair && out_trio, 1);
        if (per_on && out_pair && !prev_a) begin
            if (rise_a >= 0) chk("R1", sidx - rise_a, ra_m);
            rise_a = sidx;
        end
        if (per_on && out_trio && !prev_b) begin
            if (rise_b >= 0) chk("R2", sidx - rise_b, rb_m);
            rise_b = sidx;
        end
        prev_a = out_pair;
        prev_b = out_trio;
    endtask

    // reset over one rising edge and check the reset state
    task automatic do_reset(logic en_after);
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk("R6", out_pair, 0);
        chk("R6", out_trio, 0);
        #1 rst_n = 1'b1;
        run_en = en_after;
        prev_a = 1'b0; prev_b = 1'b0; rise_a = -1; rise_b = -1;
    endtask

    initial begin
        // exhaustive select sweep with a steady enable
        for (int sa = 0; sa < 2; sa++) begin
            for (int sb = 0; sb < 4; sb++) begin
                sel_pair = sa[0];
                sel_trio = sb[1:0];
                do_reset(1'b1);
                // first enabled edge: both rise together (R3)
                step("R3", "R3");
                chk("R3", out_pair && out_trio, 1);
                per_on = 1'b1;
                for (int i = 0; i < 60; i++) step("R1", "R2");
                per_on = 1'b0;
            end
        end

        // enable raised after the falling edge waits one extra edge (R4)
        sel_pair = 1'b0; sel_trio = 2'b00;
        do_reset(1'b0);
        step("R4", "R4");
        @(posedge clk);
        #5 run_en = 1'b1;
        #3 #2;
        chk("R4", out_pair, 0);
        chk("R4", out_trio, 0);
        step("R4", "R4");
        chk("R4", out_pair, 1);
        for (int i = 0; i < 10; i++) step("R4", "R4");
        // disable raised before the falling edge freezes the next edge
        #1 run_en = 1'b0;
        for (int i = 0; i < 5; i++) step("R4", "R4");

        // random enable toggling for every select combination (R5)
        for (int c = 0; c < 8; c++) begin
            sel_pair = c[0];
            sel_trio = c[2:1];
            do_reset(1'b1);
            for (int i = 0; i < 300; i++) begin
                step("R5", "R5");
                if ($urandom_range(0, 2) == 0) begin
                    int d = $urandom_range(0, 2);
                    #(1 + 2 * d) run_en = ~run_en;
                end
            end
        end

        // select change mid-period waits for the joint boundary (R7)
        for (int c = 0; c < 8; c++) begin
            sel_pair = c[0];
            sel_trio = c[2:1];
            do_reset(1'b1);
            for (int i = 0; i < 3 + c; i++) step("R7", "R7");
            sel_pair = ~sel_pair;
            sel_trio = sel_trio + 2'd1;
            for (int i = 0; i < 40; i++) step("R7", "R7");
        end

        // equal ratios give identical outputs (R8)
        sel_pair = 1'b1; sel_trio = 2'b00;
        do_reset(1'b1);
        for (int i = 0; i < 24; i++) begin
            step("R8", "R8");
            chk("R8", out_pair, out_trio);
        end

        // reset in mid-run brings back a clean aligned start (R6)
        sel_pair = 1'b0; sel_trio = 2'b01;
        for (int i = 0; i < 7; i++) step("R6", "R6");
        do_reset(1'b1);
        for (int i = 0; i < 20; i++) step("R6", "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule